// File: doc/BRIEF.md
# SOF Frame Number Tracker

This block sits behind the token decoder of a USB device controller and follows the host's Start-of-Frame stream. An upstream stage has already checked each SOF token. It presents the token as a one-cycle valid strobe together with the 11-bit frame number. The tracker stores that number in a frame register and raises a one-cycle SOF interrupt pulse. It also emits a local 1 ms frame tick that software and other endpoint logic can use as a time reference.

The first accepted SOF arms a loss watchdog. The host is expected to send a token every millisecond. When no token arrives within a window slightly longer than that (1.00358 ms), the frame is treated as lost. The frame register keeps its old value and a one-cycle missed-SOF pulse is produced, once for each lost frame. The local tick keeps running at its own 1 ms period through the gap. When SOFs return, both the tick and the watchdog re-phase to the cycle in which the new token arrived.

A bus reset input disarms the tracker. The tracker then stays silent until a fresh SOF is seen. The clock rate is given as a parameter in kHz. Both the period and the loss window are derived from it in clock cycles: at 60 MHz the period is 60,000 cycles and the loss window is 60,215 cycles.

Top module: `sof_frame_tracker`

## Requirements
- R1: After reset, frame_num is 0, and sof_irq, sof_miss and frame_tick are low. The tracker is disarmed.
- R2: An accepted SOF (sof_vld high, bus_rst low at a clock edge) loads sof_num into frame_num, visible in the following cycle. This holds for every value from 0x000 to 0x7FF, including the wrap from 0x7FF to 0x000.
- R3: sof_irq is high for exactly the one cycle after each accepted SOF and low otherwise.
- R4: Let LOSS = ceil(CLK_KHZ × 1.00358) cycles. An accepted SOF whose edge is at most LOSS edges after the previous accepted SOF produces no sof_miss.
- R5: While armed, if LOSS edges pass after the last accepted SOF with none accepted, sof_miss is high for one cycle, after the LOSS-th edge. frame_num keeps its value.
- R6: While SOFs stay absent, sof_miss pulses again every PERIOD = CLK_KHZ cycles after the first miss, once per lost frame.
- R7: An accepted SOF raises frame_tick in the following cycle. While armed and without new SOFs, frame_tick then pulses every PERIOD cycles, counted from the last SOF or tick. This includes the time across a loss.
- R8: Before the first accepted SOF after reset, frame_tick and sof_miss stay low.
- R9: bus_rst disarms the tracker. From then on, frame_tick and sof_miss stay low until an SOF is accepted. An sof_vld in the same cycle as bus_rst is ignored: no sof_irq is raised and frame_num is unchanged.
- R10: After an SOF arrives following a loss, the tick and the loss window restart from that SOF's edge. The next tick comes PERIOD edges later and the next miss LOSS edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock, CLK_KHZ kHz |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | USB bus reset seen; disarms the tracker |
| sof_vld | input | 1 | One-cycle strobe for a checked SOF token |
| sof_num | input | 11 | Frame number carried by the SOF |
| frame_num | output | 11 | Last accepted frame number |
| sof_irq | output | 1 | One-cycle SOF interrupt pulse |
| sof_miss | output | 1 | One-cycle pulse per lost SOF |
| frame_tick | output | 1 | Local 1 ms frame pulse |

## Verification
The bench probes the edge of the loss window. An SOF exactly LOSS edges late must not count as a miss, and with no SOF the miss must land on exactly that edge. A watchdog compare off by one would flag a miss one cycle early or late.

Repeated misses must come one period apart. A tracker that failed to reload its watchdog would fall silent after the first miss or pulse every cycle.

An SOF at an odd phase must pull the next tick and the next miss along with it. A block that free-ran without re-phasing would tick at the old phase.

A bus reset that coincides with an SOF must drop that SOF and silence ticks. A wrong priority would raise a spurious interrupt or keep ticking.

// File: rtl/sof_trk_pkg.sv
package sof_trk_pkg;

    localparam int unsigned FRAME_W = 11;

    typedef logic [FRAME_W-1:0] frame_t;

    typedef struct packed {
        logic   vld;
        frame_t num;
    } sof_evt_t;

    typedef enum logic {
        TRK_IDLE  = 1'b0,
        TRK_ARMED = 1'b1
    } trk_state_e;

    // Loss window in cycles: ceil(khz * 1.00358), computed in 64 bits.
    function automatic int unsigned loss_cycles(input int unsigned khz);
        longint unsigned num;
        num = longint'(khz) * 64'd100358 + 64'd99999;
        return int'(num / 64'd100000);
    endfunction

endpackage

// File: rtl/sft_frame_reg.sv
module sft_frame_reg
    import sof_trk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  frame_t num,
    output frame_t frame_q,
    output logic   irq_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= accept;
            if (accept) begin
                frame_q <= num;
            end
        end
    end

    AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (rst)
        accept |=> (frame_q == $past(num)));                    // R2
    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(frame_q));                          // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !irq_q);                                    // R3

endmodule

// File: rtl/sft_phase.sv
module sft_phase #(
    parameter int unsigned PERIOD = 60000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic armed,
    input  logic accept,
    output logic tick_q
);

    localparam int unsigned PW = $clog2(PERIOD);
    localparam logic [PW-1:0] PH_LAST = PW'(PERIOD - 1);

    logic [PW-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ph_q   <= '0;
            tick_q <= 1'b0;
        end else if (accept) begin
            ph_q   <= '0;
            tick_q <= 1'b1;
        end else if (armed && ph_q == PH_LAST) begin
            ph_q   <= '0;
            tick_q <= 1'b1;
        end else if (armed) begin
            ph_q   <= ph_q + 1'b1;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
        end
    end

    AST_TICK_ON_SOF: assert property (@(posedge clk) disable iff (rst)
        accept |=> tick_q);                                     // R7
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);                                    // R7

endmodule

// File: rtl/sft_watchdog.sv
module sft_watchdog #(
    parameter int unsigned PERIOD = 60000,
    parameter int unsigned LOSS   = 60215
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic armed,
    input  logic accept,
    output logic miss_q
);

    localparam int unsigned CW = $clog2(LOSS + 1);
    localparam logic [CW-1:0] W_LAST   = CW'(LOSS - 1);
    localparam logic [CW-1:0] W_RELOAD = CW'(LOSS - PERIOD);

    logic [CW-1:0] w_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            w_q    <= '0;
            miss_q <= 1'b0;
        end else if (accept) begin
            w_q    <= '0;
            miss_q <= 1'b0;
        end else if (armed && w_q == W_LAST) begin
            w_q    <= W_RELOAD;
            miss_q <= 1'b1;
        end else if (armed) begin
            w_q    <= w_q + 1'b1;
            miss_q <= 1'b0;
        end else begin
            miss_q <= 1'b0;
        end
    end

    AST_NO_MISS_ON_SOF: assert property (@(posedge clk) disable iff (rst)
        accept |=> !miss_q);                                    // R4
    AST_MISS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        miss_q |=> !miss_q);                                    // R5

endmodule

// File: rtl/sof_frame_tracker.sv
module sof_frame_tracker
    import sof_trk_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 60000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_rst,
    input  logic        sof_vld,
    input  logic [10:0] sof_num,
    output logic [10:0] frame_num,
    output logic        sof_irq,
    output logic        sof_miss,
    output logic        frame_tick
);

    localparam int unsigned PERIOD_CYC = CLK_KHZ;
    localparam int unsigned LOSS_CYC   = loss_cycles(CLK_KHZ);

    sof_evt_t   evt;
    logic       accept;
    logic       armed;
    trk_state_e state_q;

    assign evt.vld = sof_vld;
    assign evt.num = sof_num;
    assign accept  = evt.vld && !bus_rst;
    assign armed   = (state_q == TRK_ARMED);

    always_ff @(posedge clk) begin
        if (rst || bus_rst) begin
            state_q <= TRK_IDLE;
        end else if (accept) begin
            state_q <= TRK_ARMED;
        end
    end

    sft_frame_reg u_freg (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .num     (evt.num),
        .frame_q (frame_num),
        .irq_q   (sof_irq)
    );

    sft_phase #(.PERIOD(PERIOD_CYC)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .clear  (bus_rst),
        .armed  (armed),
        .accept (accept),
        .tick_q (frame_tick)
    );

    sft_watchdog #(.PERIOD(PERIOD_CYC), .LOSS(LOSS_CYC)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .clear  (bus_rst),
        .armed  (armed),
        .accept (accept),
        .miss_q (sof_miss)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (!frame_tick && !sof_miss));                 // R8
    AST_BUSRST_DROP: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> (!sof_irq && !frame_tick && !sof_miss));    // R9

endmodule

// File: tb/sim_sof_frame_tracker.sv
module sim_sof_frame_tracker;

    localparam int unsigned KHZ  = 1000;
    localparam int          PER  = 1000;
    localparam int          LOSS = 1004;   // ceil(1000 * 1.00358)

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rst = 1'b0;
    logic        sof_vld = 1'b0;
    logic [10:0] sof_num = '0;
    logic [10:0] frame_num;
    logic        sof_irq, sof_miss, frame_tick;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    sof_frame_tracker #(.CLK_KHZ(KHZ)) u0 (
        .clk(clk), .rst(rst), .bus_rst(bus_rst), .sof_vld(sof_vld),
        .sof_num(sof_num), .frame_num(frame_num), .sof_irq(sof_irq),
        .sof_miss(sof_miss), .frame_tick(frame_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One accepted SOF; returns at the negedge after its edge.
    task automatic send_sof(input logic [10:0] n);
        @(negedge clk);
        sof_vld = 1'b1;
        sof_num = n;
        @(negedge clk);
        sof_vld = 1'b0;
    endtask

    // Idle n edges; offsets are edges after the last SOF edge (1-based).
    task automatic run_idle(input int n, output int ticks, output int misses,
                            output int first_tick, output int first_miss);
        ticks = 0; misses = 0; first_tick = -1; first_miss = -1;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (frame_tick) begin
                if (first_tick < 0) first_tick = k;
                ticks++;
            end
            if (sof_miss) begin
                if (first_miss < 0) first_miss = k;
                misses++;
            end
        end
    endtask

    task automatic t_reset();
        chk(frame_num == 0, "R1 frame", int'(frame_num), 0);
        chk(!sof_irq && !sof_miss && !frame_tick, "R1 pulses",
            {sof_irq, sof_miss, frame_tick}, 0);
    endtask

    task automatic t_unarmed();
        int tk, ms, ft, fm;
        run_idle(3000, tk, ms, ft, fm);
        chk(tk == 0, "R8 ticks", tk, 0);
        chk(ms == 0, "R8 misses", ms, 0);
    endtask

    task automatic t_first_sof();
        int tk, ms, ft, fm;
        send_sof(11'h123);
        chk(frame_num == 11'h123, "R2 latch", int'(frame_num), 'h123);
        chk(sof_irq == 1'b1, "R3 irq", int'(sof_irq), 1);
        chk(frame_tick == 1'b1, "R7 tick on sof", int'(frame_tick), 1);
        run_idle(1, tk, ms, ft, fm);
        chk(sof_irq == 1'b0, "R3 irq one cycle", int'(sof_irq), 0);
    endtask

    task automatic t_on_time();
        int tk, ms, ft, fm;
        send_sof(11'h7FF);
        run_idle(LOSS - 1, tk, ms, ft, fm);
        chk(ft == PER, "R7 tick period", ft, PER);
        chk(ms == 0, "R4 no miss in window", ms, 0);
        send_sof(11'h000);
        chk(sof_miss == 1'b0, "R4 sof at window edge", int'(sof_miss), 0);
        chk(frame_num == 11'h000, "R2 wrap", int'(frame_num), 0);
    endtask

    task automatic t_loss();
        int tk, ms, ft, fm;
        send_sof(11'h010);
        run_idle(LOSS, tk, ms, ft, fm);
        chk(fm == LOSS, "R5 miss edge", fm, LOSS);
        chk(ms == 1, "R5 miss count", ms, 1);
        chk(frame_num == 11'h010, "R5 frame held", int'(frame_num), 'h010);
        run_idle(PER, tk, ms, ft, fm);
        chk(fm == PER && ms == 1, "R6 repeat miss", fm, PER);
        chk(tk == 1, "R7 tick across loss", tk, 1);
    endtask

    task automatic t_resync();
        int tk, ms, ft, fm;
        run_idle(337, tk, ms, ft, fm);
        send_sof(11'h200);
        chk(frame_tick == 1'b1, "R7 re-phase tick", int'(frame_tick), 1);
        run_idle(LOSS, tk, ms, ft, fm);
        chk(ft == PER, "R10 tick after resync", ft, PER);
        chk(fm == LOSS, "R10 miss after resync", fm, LOSS);
    endtask

    task automatic t_bus_reset();
        int tk, ms, ft, fm;
        send_sof(11'h0AA);
        @(negedge clk);
        bus_rst = 1'b1;
        sof_vld = 1'b1;
        sof_num = 11'h055;
        @(negedge clk);
        bus_rst = 1'b0;
        sof_vld = 1'b0;
        chk(sof_irq == 1'b0, "R9 sof dropped irq", int'(sof_irq), 0);
        chk(frame_num == 11'h0AA, "R9 frame kept", int'(frame_num), 'h0AA);
        run_idle(2500, tk, ms, ft, fm);
        chk(tk == 0 && ms == 0, "R9 silent", tk + ms, 0);
        send_sof(11'h321);
        chk(sof_irq && frame_num == 11'h321, "R9 re-arm", int'(frame_num), 'h321);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unarmed();
        t_first_sof();
        t_on_time();
        t_loss();
        t_resync();
        t_bus_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule